// File: doc/BRIEF.md
# Oscillator Control Registers and Lookup-Memory Owner Switch

This block sits between a host processor and an external asynchronous lookup memory that holds waveform samples for a numerically controlled oscillator. It keeps three 32-bit words that the host writes and reads back: a tuning (frequency) word, a starting-phase word and a control word. The tuning and phase words are presented continuously to the oscillator datapath, which lives outside this block.

Bit 0 of the control word decides which side owns the memory. When the bit is clear, the oscillator's sample address goes straight to the memory pins and the memory is held in a read state, so the returned word streams back to the oscillator. When the bit is set, the host owns the memory. Through a latched memory-address register and a data window register it can fill the table and read it back. The expected start-up order is: set the bit, load the table, program the tuning and phase words, then clear the bit to start the oscillator.

Host accesses are synchronous single-cycle strobes. Read data appears on the cycle after the read strobe. Memory writes are registered, so the write-enable pulse and the driven data reach the pins one cycle after the host strobe.

Top module: `osc_lut_hostif`

## Requirements
- R1: After reset, the tuning, phase, control and memory-address registers read as zero, the read data output is zero, and the oscillator owns the memory.
- R2: Host address 0 holds the tuning word, 1 the phase word and 2 the control word. A write stores all 32 bits, and a read strobe returns the stored value on `h_rdata` one cycle later.
- R3: `freq_word` and `phase_word` equal the stored tuning and phase words from the cycle after a write.
- R4: Only bit 0 of the control word selects the owner. The other 31 bits are stored and read back but have no effect on the memory pins.
- R5: With control bit 0 clear, `mem_addr` follows `nco_addr`, chip enable and output enable are low, write enable is high, `mem_dq_oe` is low, and `nco_rdata` equals `mem_dq_i`.
- R6: With control bit 0 set, `mem_addr` shows the memory-address register (address 4, low MAW bits of the write data), and `nco_rdata` is zero.
- R7: A host write to address 3 while the host owns the memory produces, in the next cycle only, `mem_we_n` low, `mem_oe_n` high, `mem_dq_oe` high, `mem_dq_o` equal to the written data and `mem_addr` equal to the memory-address register at the time of the strobe. In every other cycle `mem_dq_oe` is low.
- R8: A host write to address 3 while the oscillator owns the memory is ignored: no write pulse appears and the table keeps its old contents.
- R9: A host read of address 3 returns the memory word at the memory-address register when the host owns the memory, and zero otherwise.
- R10: A read of address 4 returns the memory-address register zero-extended. Reads of addresses 5 to 7 return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| h_addr | input | 3 | Host register address |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data, valid the cycle after `h_rd` |
| freq_word | output | DW | Tuning word to the oscillator |
| phase_word | output | DW | Phase word to the oscillator |
| nco_addr | input | MAW | Oscillator sample address |
| nco_rdata | output | DW | Sample word returned to the oscillator |
| mem_addr | output | MAW | Memory address pins |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq_o | output | DW | Data driven toward the memory |
| mem_dq_oe | output | 1 | Pad drive enable for `mem_dq_o`; low means the bus is released |
| mem_dq_i | input | DW | Data returned by the memory |

## Verification
A wrong owner bit shows on `mem_addr` in the cycle after the control write: it follows the host address register instead of `nco_addr`, or the reverse, and `nco_rdata` goes to zero or stops being zero at the same time. A corrupted register shows on `freq_word` or `phase_word` at once and on `h_rdata` one cycle after a read. A bad write-cycle state shows either as a write-enable pulse that should not occur, which corrupts a table entry that a later sweep catches, or as the drive enable being high outside its one cycle. The table is filled and read back over every entry of a small address space, both through the host window and through the oscillator path.

// File: rtl/osc_lut_pkg.sv
package osc_lut_pkg;

  localparam int unsigned HADDR_W = 3;

  typedef enum logic [HADDR_W-1:0] {
    RA_TUNE  = 3'd0,
    RA_PHASE = 3'd1,
    RA_CTRL  = 3'd2,
    RA_WIN   = 3'd3,
    RA_MADR  = 3'd4
  } host_reg_e;

  function automatic logic is_reg(input logic [HADDR_W-1:0] a, input host_reg_e r);
    return a == HADDR_W'(r);
  endfunction

endpackage

// File: rtl/osc_lut_rst_sync.sv
module osc_lut_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/osc_lut_regs.sv
module osc_lut_regs
  import osc_lut_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned MAW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic               h_wr,
  input  logic               h_rd,
  input  logic [DW-1:0]      h_wdata,
  output logic [DW-1:0]      h_rdata,
  input  logic [DW-1:0]      win_rdata,
  output logic [DW-1:0]      tune_q,
  output logic [DW-1:0]      phase_q,
  output logic [DW-1:0]      ctrl_q,
  output logic [MAW-1:0]     madr_q,
  output logic               wcyc_q,
  output logic [MAW-1:0]     wadr_q,
  output logic [DW-1:0]      wdat_q
);
  localparam int unsigned PADW = DW - MAW;

  logic [DW-1:0]  tune_d, phase_d, ctrl_d, rdata_d;
  logic [MAW-1:0] madr_d, wadr_d;
  logic [DW-1:0]  wdat_d;
  logic           wcyc_d;
  logic           host_own;

  assign host_own = ctrl_q[0];

  always_comb begin
    tune_d  = tune_q;
    phase_d = phase_q;
    ctrl_d  = ctrl_q;
    madr_d  = madr_q;
    wcyc_d  = 1'b0;
    wadr_d  = wadr_q;
    wdat_d  = wdat_q;
    rdata_d = h_rdata;
    if (h_wr) begin
      if (is_reg(h_addr, RA_TUNE))  tune_d  = h_wdata;
      if (is_reg(h_addr, RA_PHASE)) phase_d = h_wdata;
      if (is_reg(h_addr, RA_CTRL))  ctrl_d  = h_wdata;
      if (is_reg(h_addr, RA_MADR))  madr_d  = h_wdata[MAW-1:0];
      if (is_reg(h_addr, RA_WIN) && host_own) begin
        wcyc_d = 1'b1;
        wadr_d = madr_q;
        wdat_d = h_wdata;
      end
    end
    if (h_rd) begin
      unique case (h_addr)
        HADDR_W'(RA_TUNE):  rdata_d = tune_q;
        HADDR_W'(RA_PHASE): rdata_d = phase_q;
        HADDR_W'(RA_CTRL):  rdata_d = ctrl_q;
        HADDR_W'(RA_WIN):   rdata_d = win_rdata;
        HADDR_W'(RA_MADR):  rdata_d = {{PADW{1'b0}}, madr_q};
        default:            rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tune_q  <= '0;
      phase_q <= '0;
      ctrl_q  <= '0;
      madr_q  <= '0;
      wcyc_q  <= 1'b0;
      wadr_q  <= '0;
      wdat_q  <= '0;
      h_rdata <= '0;
    end else begin
      tune_q  <= tune_d;
      phase_q <= phase_d;
      ctrl_q  <= ctrl_d;
      madr_q  <= madr_d;
      wcyc_q  <= wcyc_d;
      h_rdata <= rdata_d;
      if (wcyc_d) begin
        wadr_q <= wadr_d;
        wdat_q <= wdat_d;
      end
    end
  end

  // R8
  win_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == HADDR_W'(RA_WIN) && !ctrl_q[0]) |=> !wcyc_q);

  // R2
  tune_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == HADDR_W'(RA_TUNE)) |=> (tune_q == $past(h_wdata)));

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_addr > HADDR_W'(RA_MADR)) |=> (h_rdata == '0));
endmodule

// File: rtl/osc_lut_port_sel.sv
module osc_lut_port_sel #(
  parameter int unsigned DW  = 32,
  parameter int unsigned MAW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_own,
  input  logic [MAW-1:0] madr,
  input  logic           wcyc,
  input  logic [MAW-1:0] wadr,
  input  logic [DW-1:0]  wdat,
  input  logic [MAW-1:0] nco_addr,
  output logic [DW-1:0]  nco_rdata,
  output logic [DW-1:0]  host_rdata,
  output logic [MAW-1:0] mem_addr,
  output logic           mem_ce_n,
  output logic           mem_oe_n,
  output logic           mem_we_n,
  output logic [DW-1:0]  mem_dq_o,
  output logic           mem_dq_oe,
  input  logic [DW-1:0]  mem_dq_i
);
  logic host_wr;

  assign host_wr = host_own & wcyc;

  always_comb begin
    mem_ce_n   = 1'b0;
    mem_oe_n   = 1'b0;
    mem_we_n   = 1'b1;
    mem_dq_oe  = 1'b0;
    mem_dq_o   = '0;
    nco_rdata  = '0;
    host_rdata = '0;
    if (host_own) begin
      mem_addr   = wcyc ? wadr : madr;
      host_rdata = mem_dq_i;
      if (host_wr) begin
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b0;
        mem_dq_oe = 1'b1;
        mem_dq_o  = wdat;
      end
    end else begin
      mem_addr  = nco_addr;
      nco_rdata = mem_dq_i;
    end
  end

  // R7
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> mem_we_n);

  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_we_n));
endmodule

// File: rtl/osc_lut_hostif.sv
module osc_lut_hostif
  import osc_lut_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned MAW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic               h_wr,
  input  logic               h_rd,
  input  logic [DW-1:0]      h_wdata,
  output logic [DW-1:0]      h_rdata,
  output logic [DW-1:0]      freq_word,
  output logic [DW-1:0]      phase_word,
  input  logic [MAW-1:0]     nco_addr,
  output logic [DW-1:0]      nco_rdata,
  output logic [MAW-1:0]     mem_addr,
  output logic               mem_ce_n,
  output logic               mem_oe_n,
  output logic               mem_we_n,
  output logic [DW-1:0]      mem_dq_o,
  output logic               mem_dq_oe,
  input  logic [DW-1:0]      mem_dq_i
);
  logic           srst_n;
  logic [DW-1:0]  ctrl_q, win_rdata, wdat_q;
  logic [MAW-1:0] madr_q, wadr_q;
  logic           wcyc_q;

  osc_lut_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  osc_lut_regs #(.DW(DW), .MAW(MAW)) i_regs (
    .clk(clk), .rst_n(srst_n),
    .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .win_rdata(win_rdata),
    .tune_q(freq_word), .phase_q(phase_word), .ctrl_q(ctrl_q), .madr_q(madr_q),
    .wcyc_q(wcyc_q), .wadr_q(wadr_q), .wdat_q(wdat_q)
  );

  osc_lut_port_sel #(.DW(DW), .MAW(MAW)) i_sel (
    .clk(clk), .rst_n(srst_n),
    .host_own(ctrl_q[0]), .madr(madr_q), .wcyc(wcyc_q), .wadr(wadr_q), .wdat(wdat_q),
    .nco_addr(nco_addr), .nco_rdata(nco_rdata), .host_rdata(win_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // R5
  nco_owner_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !ctrl_q[0] |-> (mem_we_n && !mem_dq_oe && mem_addr == nco_addr));

  // R7
  pulse_host_owned_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !mem_we_n |-> ctrl_q[0]);
endmodule

// File: tb/test_osc_lut_hostif.sv
module test_osc_lut_hostif;
  localparam int DW  = 32;
  localparam int MAW = 6;
  localparam int N   = 1 << MAW;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2:0]     h_addr = '0;
  logic           h_wr = 1'b0, h_rd = 1'b0;
  logic [DW-1:0]  h_wdata = '0;
  logic [DW-1:0]  h_rdata, freq_word, phase_word, nco_rdata, mem_dq_o;
  logic [MAW-1:0] nco_addr = '0;
  logic [MAW-1:0] mem_addr;
  logic           mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0]  mem_dq_i;
  logic [DW-1:0]  table_q [N];

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  osc_lut_hostif #(.DW(DW), .MAW(MAW)) i_osc_lut_hostif (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .freq_word(freq_word), .phase_word(phase_word),
    .nco_addr(nco_addr), .nco_rdata(nco_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // asynchronous memory model
  assign mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_we_n) ? table_q[mem_addr] : 32'hBAD0_BAD0;
  always @(posedge clk)
    if (!mem_ce_n && !mem_we_n) table_q[mem_addr] <= mem_dq_o;

  function automatic logic [DW-1:0] pat(input int i);
    return (32'(i) * 32'h0001_0203) ^ 32'hC3A5_5A3C;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); h_addr = a; h_wdata = d; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic hread(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk); h_addr = a; h_rd = 1'b1;
    @(negedge clk); h_rd = 1'b0; d = h_rdata;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] rd;
    for (int i = 0; i < N; i++) table_q[i] = '0;
    nco_addr = 6'd5;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1 rdata", h_rdata, '0);
    check("R1 freq", freq_word, '0);
    check("R1 phase", phase_word, '0);
    check("R1 we_n", 32'(mem_we_n), 32'd1);
    check("R1 dq_oe", 32'(mem_dq_oe), 32'd0);
    check("R1 owner addr", 32'(mem_addr), 32'd5);
    hread(3'd2, rd); check("R1 ctrl", rd, '0);
    hread(3'd4, rd); check("R1 madr", rd, '0);

    // R2 R3: tuning and phase words
    hwrite(3'd0, 32'h1234_5678);
    check("R3 freq_word", freq_word, 32'h1234_5678);
    hwrite(3'd1, 32'h9ABC_DEF0);
    check("R3 phase_word", phase_word, 32'h9ABC_DEF0);
    hread(3'd0, rd); check("R2 tune read", rd, 32'h1234_5678);
    hread(3'd1, rd); check("R2 phase read", rd, 32'h9ABC_DEF0);

    // R6: host owns
    hwrite(3'd2, 32'h0000_0001);
    hread(3'd2, rd); check("R2 ctrl read", rd, 32'h1);
    hwrite(3'd4, 32'h0000_0011);
    check("R6 mem_addr", 32'(mem_addr), 32'h11);
    check("R6 nco_rdata", nco_rdata, '0);

    // R7: fill whole table
    for (int i = 0; i < N; i++) begin
      hwrite(3'd4, 32'(i));
      hwrite(3'd3, pat(i));
      check("R7 we_n low", 32'(mem_we_n), 32'd0);
      check("R7 oe_n high", 32'(mem_oe_n), 32'd1);
      check("R7 dq_oe", 32'(mem_dq_oe), 32'd1);
      check("R7 dq_o", mem_dq_o, pat(i));
      check("R7 addr", 32'(mem_addr), 32'(i));
      @(negedge clk);
      check("R7 we_n released", 32'(mem_we_n), 32'd1);
      check("R7 dq released", 32'(mem_dq_oe), 32'd0);
    end

    // R9: host readback sweep
    for (int i = 0; i < N; i++) begin
      hwrite(3'd4, 32'(i));
      hread(3'd3, rd); check("R9 window read", rd, pat(i));
    end

    // R10: address register width
    hwrite(3'd4, 32'hFFFF_FFC5);
    hread(3'd4, rd); check("R10 madr zero-ext", rd, 32'h05);

    // R5: oscillator owns, sweep its addresses
    hwrite(3'd2, 32'h0);
    for (int i = 0; i < N; i++) begin
      @(negedge clk); nco_addr = MAW'(i); #1;
      check("R5 addr", 32'(mem_addr), 32'(i));
      check("R5 nco_rdata", nco_rdata, pat(i));
      check("R5 strobes", {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'b001);
    end

    // R9: window reads zero when not owned
    hread(3'd3, rd); check("R9 window not owned", rd, '0);

    // R8: window write ignored when not owned
    hwrite(3'd3, 32'hDEAD_0000);
    check("R8 no pulse", 32'(mem_we_n), 32'd1);
    check("R8 no drive", 32'(mem_dq_oe), 32'd0);
    hwrite(3'd2, 32'h1);
    hread(3'd3, rd); check("R8 table kept", rd, pat(5));

    // R4: upper control bits have no effect
    hwrite(3'd2, 32'hFFFF_FFFE);
    nco_addr = 6'd42; #1;
    check("R4 nco owns addr", 32'(mem_addr), 32'd42);
    check("R4 nco rdata", nco_rdata, pat(42));
    hread(3'd2, rd); check("R4 ctrl kept", rd, 32'hFFFF_FFFE);
    hwrite(3'd2, 32'h8000_0001);
    check("R4 host owns addr", 32'(mem_addr), 32'd5);

    // R10: unmapped addresses
    for (int a = 5; a < 8; a++) begin
      hwrite(3'(a), 32'h5555_AAAA);
      hread(3'(a), rd); check("R10 unmapped read", rd, '0);
    end
    hread(3'd0, rd); check("R10 tune untouched", rd, 32'h1234_5678);
    hread(3'd4, rd); check("R10 madr untouched", rd, 32'h05);

    finish_run();
  end
endmodule